// File: doc/BRIEF.md
# Compare Flag Evaluation Unit

This unit covers the flag-only comparison work of a small 32-bit execute stage. Each cycle it can take one operation: a subtract-compare of a register against another register, a subtract-compare of a register against an 8-bit immediate, or an add-compare of two registers. It reads its operands from a local 15-entry register file, forms the difference or the sum, and loads the negative, zero, carry and overflow flags into a flag register. The arithmetic result itself is thrown away, and no register is ever written by an operation.

The add-compare may only name the lower eight registers. The subtract-compare may name any of the fifteen. When an index breaks the rule for its form, or the operation select holds the unused code, the unit raises an illegal-encoding output in the same cycle and leaves the flags as they were. A separate preload port fills the register file, and only this port writes the file.

Top module: `cmp_flag_unit`

## Requirements
- R1: With `opSel` = 2'b00 and a legal encoding, the flags reflect Rn minus Rm (register indices `rnIdx`, `rmIdx`).
- R2: With `opSel` = 2'b01 and a legal encoding, the flags reflect Rn minus `immVal` zero-extended to 32 bits, and `rmIdx` has no effect.
- R3: With `opSel` = 2'b10 and a legal encoding, the flags reflect Rn plus Rm.
- R4: `flagsOut` bit 3 is N (result bit 31), bit 2 is Z (all 32 result bits zero), bit 1 is C, and bit 0 is V. For subtraction C is set when Rn is greater than or equal to the operand as unsigned values. For addition C is the carry out of bit 31. V is set on two's-complement signed overflow.
- R5: With `opSel` = 2'b10, a `rnIdx` or `rmIdx` of 8 or more drives `illegalOut` high in that cycle, and the flags keep their value.
- R6: With `opSel` = 2'b00, an index of 15 in `rnIdx` or `rmIdx` drives `illegalOut` high. With `opSel` = 2'b01, a `rnIdx` of 15 does the same. `opSel` = 2'b11 is always illegal. In every one of these cases the flags keep their value.
- R7: The flags change only on a rising clock edge where `opValid` is high and the encoding is legal. When `opValid` is low, `illegalOut` is low and the flags hold.
- R8: Compare operations never change the register file. A later compare sees the values that were preloaded.
- R9: A synchronous active-high `rst` clears all four flags to zero.
- R10: A preload with `preWe` high writes `preData` into entry `preIdx` at the rising edge, and an operation in any later cycle reads the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, clears the flags |
| opValid | input | 1 | An operation is presented this cycle |
| opSel | input | 2 | 00 subtract Rm, 01 subtract immediate, 10 add Rm, 11 unused |
| rnIdx | input | 4 | First operand register index |
| rmIdx | input | 4 | Second operand register index |
| immVal | input | 8 | Unsigned immediate for the subtract-immediate form |
| preWe | input | 1 | Preload write enable |
| preIdx | input | 4 | Preload entry index |
| preData | input | 32 | Preload data |
| flagsOut | output | 4 | {N, Z, C, V} flag register |
| illegalOut | output | 1 | Combinational illegal-encoding indication for the presented operation |

## Verification
The bench builds the unit with its default parameters: 32-bit data, 15 register entries and an 8-entry low window for the add-compare. With these values, index 15 lies one past the file, so it is reachable by random indices. Indices 8 to 14 separate the two range rules. The 32-bit sign boundaries at 0x7FFFFFFF and 0x80000000 can be preloaded directly, so carry, borrow and signed overflow are exercised at their exact edges as well as under random operands.

// File: rtl/cmp_flag_pkg.sv
package cmp_flag_pkg;

  typedef enum logic [1:0] {
    OP_SUB_REG = 2'b00,
    OP_SUB_IMM = 2'b01,
    OP_ADD_REG = 2'b10,
    OP_UNUSED  = 2'b11
  } cmpOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic useImm;
    logic doAdd;
    logic flagWe;
  } cmpStrobe_t;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

endpackage

// File: rtl/cmp_regfile.sv
module cmp_regfile #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 15,
  parameter int IDX_W    = 4
) (
  input  logic              clk,
  input  logic              preWe,
  input  logic [IDX_W-1:0]  preIdx,
  input  logic [DATA_W-1:0] preData,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [IDX_W-1:0]  rdIdxB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);

  logic [DATA_W-1:0] mem [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (preWe && (preIdx == IDX_W'(g)))
        mem[g] <= preData;
    end
  end

  function automatic logic [DATA_W-1:0] readEntry(input logic [IDX_W-1:0] idx);
    logic [DATA_W-1:0] val;
    val = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == IDX_W'(i)) val = mem[i];
    return val;
  endfunction

  assign rdDataA = readEntry(rdIdxA);
  assign rdDataB = readEntry(rdIdxB);

  // R10
  preload_write_chk: assert property (@(posedge clk)
    (preWe && (int'(preIdx) < NUM_REGS)) |=> (readEntry($past(preIdx)) == $past(preData)));

endmodule

// File: rtl/cmp_control.sv
module cmp_control
  import cmp_flag_pkg::*;
#(
  parameter int IDX_W       = 4,
  parameter int NUM_REGS    = 15,
  parameter int NARROW_REGS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             opValid,
  input  logic [1:0]       opSel,
  input  logic [IDX_W-1:0] rnIdx,
  input  logic [IDX_W-1:0] rmIdx,
  output cmpStrobe_t       strb,
  output logic             illegalOut
);

  localparam logic [IDX_W-1:0] WIDE_MAX   = IDX_W'(NUM_REGS - 1);
  localparam logic [IDX_W-1:0] NARROW_MAX = IDX_W'(NARROW_REGS - 1);

  cmpOp_e opKind;
  logic   rnWideOk, rmWideOk, rnNarrowOk, rmNarrowOk;
  logic   legal;

  assign opKind     = cmpOp_e'(opSel);
  assign rnWideOk   = (rnIdx <= WIDE_MAX);
  assign rmWideOk   = (rmIdx <= WIDE_MAX);
  assign rnNarrowOk = (rnIdx <= NARROW_MAX);
  assign rmNarrowOk = (rmIdx <= NARROW_MAX);

  always_comb begin
    legal       = 1'b0;
    strb.useImm = 1'b0;
    strb.doAdd  = 1'b0;
    unique case (opKind)
      OP_SUB_REG: legal = rnWideOk && rmWideOk;
      OP_SUB_IMM: begin
        legal       = rnWideOk;
        strb.useImm = 1'b1;
      end
      OP_ADD_REG: begin
        legal      = rnNarrowOk && rmNarrowOk;
        strb.doAdd = 1'b1;
      end
      default:    legal = 1'b0;
    endcase
    strb.flagWe = opValid && legal;
    illegalOut  = opValid && !legal;
  end

  // R5
  add_range_chk: assert property (@(posedge clk) disable iff (rst)
    (opValid && opSel == 2'b10 && (int'(rnIdx) >= NARROW_REGS || int'(rmIdx) >= NARROW_REGS))
      |-> (illegalOut && !strb.flagWe));

  // R6
  sub_range_chk: assert property (@(posedge clk) disable iff (rst)
    (opValid && opSel == 2'b00 && (int'(rnIdx) >= NUM_REGS || int'(rmIdx) >= NUM_REGS))
      |-> (illegalOut && !strb.flagWe));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !opValid |-> (!illegalOut && !strb.flagWe));

endmodule

// File: rtl/cmp_datapath.sv
module cmp_datapath
  import cmp_flag_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 15,
  parameter int IDX_W    = 4,
  parameter int IMM_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  cmpStrobe_t        strb,
  input  logic [IDX_W-1:0]  rnIdx,
  input  logic [IDX_W-1:0]  rmIdx,
  input  logic [IMM_W-1:0]  immVal,
  input  logic              preWe,
  input  logic [IDX_W-1:0]  preIdx,
  input  logic [DATA_W-1:0] preData,
  output logic [3:0]        flagReg
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] rnData, rmData, operand, effOperand, result;
  logic [DATA_W:0]   wideSum;
  logic [3:0]        flagNext;

  cmp_regfile #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W)
  ) u_regs (
    .clk    (clk),
    .preWe  (preWe),
    .preIdx (preIdx),
    .preData(preData),
    .rdIdxA (rnIdx),
    .rdIdxB (rmIdx),
    .rdDataA(rnData),
    .rdDataB(rmData)
  );

  // Operand select, then invert-plus-one for the subtract form
  assign operand    = strb.useImm ? DATA_W'(immVal) : rmData;
  assign effOperand = strb.doAdd ? operand : ~operand;
  assign wideSum    = {1'b0, rnData} + {1'b0, effOperand} + {{DATA_W{1'b0}}, !strb.doAdd};
  assign result     = wideSum[MSB:0];

  always_comb begin
    flagNext         = '0;
    flagNext[FLAG_N] = result[MSB];
    flagNext[FLAG_Z] = (result == '0);
    flagNext[FLAG_C] = wideSum[DATA_W];
    flagNext[FLAG_V] = (rnData[MSB] == effOperand[MSB]) && (result[MSB] != rnData[MSB]);
  end

  always_ff @(posedge clk) begin
    if (rst)              flagReg <= '0;
    else if (strb.flagWe) flagReg <= flagNext;
  end

  // R9
  reset_clear_chk: assert property (@(posedge clk) rst |=> (flagReg == '0));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.flagWe |=> $stable(flagReg));

  // R4
  zero_not_neg_chk: assert property (@(posedge clk) disable iff (rst)
    strb.flagWe |=> !(flagReg[FLAG_Z] && flagReg[FLAG_N]));

  // R1
  equal_no_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.flagWe && !strb.doAdd) |=> (!flagReg[FLAG_Z] || flagReg[FLAG_C]));

endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
  import cmp_flag_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_REGS    = 15,
  parameter int NARROW_REGS = 8,
  parameter int IDX_W       = 4,
  parameter int IMM_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opValid,
  input  logic [1:0]        opSel,
  input  logic [IDX_W-1:0]  rnIdx,
  input  logic [IDX_W-1:0]  rmIdx,
  input  logic [IMM_W-1:0]  immVal,
  input  logic              preWe,
  input  logic [IDX_W-1:0]  preIdx,
  input  logic [DATA_W-1:0] preData,
  output logic [3:0]        flagsOut,
  output logic              illegalOut
);

  cmpStrobe_t strb;

  cmp_control #(
    .IDX_W      (IDX_W),
    .NUM_REGS   (NUM_REGS),
    .NARROW_REGS(NARROW_REGS)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .opValid   (opValid),
    .opSel     (opSel),
    .rnIdx     (rnIdx),
    .rmIdx     (rmIdx),
    .strb      (strb),
    .illegalOut(illegalOut)
  );

  cmp_datapath #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W),
    .IMM_W   (IMM_W)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .rnIdx  (rnIdx),
    .rmIdx  (rmIdx),
    .immVal (immVal),
    .preWe  (preWe),
    .preIdx (preIdx),
    .preData(preData),
    .flagReg(flagsOut)
  );

endmodule

// File: tb/tb_cmp_flag_unit.sv
`timescale 1ns/1ps
module tb_cmp_flag_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opValid = 1'b0;
  logic [1:0]  opSel = '0;
  logic [3:0]  rnIdx = '0, rmIdx = '0, preIdx = '0;
  logic [7:0]  immVal = '0;
  logic        preWe = 1'b0;
  logic [31:0] preData = '0;
  logic [3:0]  flagsOut;
  logic        illegalOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] model [15];
  logic [3:0]  expFlags = '0;

  always #2 clk = ~clk;

  cmp_flag_unit dut (
    .clk(clk), .rst(rst), .opValid(opValid), .opSel(opSel),
    .rnIdx(rnIdx), .rmIdx(rmIdx), .immVal(immVal),
    .preWe(preWe), .preIdx(preIdx), .preData(preData),
    .flagsOut(flagsOut), .illegalOut(illegalOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Flags per R4, computed from wide unsigned and signed arithmetic
  function automatic logic [3:0] calcFlags(input bit isAdd, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] res;
    longint sres;
    bit c, v;
    if (isAdd) begin
      res  = a + b;
      c    = ({32'd0, a} + {32'd0, b}) > 64'hFFFF_FFFF;
      sres = longint'($signed(a)) + longint'($signed(b));
    end else begin
      res  = a - b;
      c    = (a >= b);
      sres = longint'($signed(a)) - longint'($signed(b));
    end
    v = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
    return {res[31], res == 32'd0, c, v};
  endfunction

  function automatic bit isIllegal(input logic [1:0] sel, input logic [3:0] rn, input logic [3:0] rm);
    case (sel)
      2'b00:   return (rn == 4'd15) || (rm == 4'd15);
      2'b01:   return (rn == 4'd15);
      2'b10:   return (rn >= 4'd8) || (rm >= 4'd8);
      default: return 1'b1;
    endcase
  endfunction

  task automatic preload(input logic [3:0] idx, input logic [31:0] data);
    @(negedge clk);
    preWe = 1'b1; preIdx = idx; preData = data;
    @(negedge clk);
    preWe = 1'b0;
    if (idx < 4'd15) model[idx] = data;
  endtask

  task automatic runOp(input logic [1:0] sel, input logic [3:0] rn, input logic [3:0] rm,
                       input logic [7:0] imm);
    bit bad;
    string tag;
    @(negedge clk);
    opValid = 1'b1; opSel = sel; rnIdx = rn; rmIdx = rm; immVal = imm;
    bad = isIllegal(sel, rn, rm);
    case (sel)
      2'b00: tag = bad ? "R6 sub-reg illegal" : "R1 sub-reg";
      2'b01: tag = bad ? "R6 sub-imm illegal" : "R2 sub-imm";
      2'b10: tag = bad ? "R5 add illegal" : "R3 add";
      default: tag = "R6 unused select";
    endcase
    #1;
    check({tag, " illegalOut"}, 32'(illegalOut), 32'(bad));
    if (!bad) begin
      case (sel)
        2'b00: expFlags = calcFlags(1'b0, model[rn], model[rm]);
        2'b01: expFlags = calcFlags(1'b0, model[rn], {24'd0, imm});
        default: expFlags = calcFlags(1'b1, model[rn], model[rm]);
      endcase
    end
    @(negedge clk);
    opValid = 1'b0;
    check({tag, " R4 R7 flags"}, 32'(flagsOut), 32'(expFlags));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    for (int i = 0; i < 15; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check("R9 reset flags", 32'(flagsOut), 32'd0);
    #1 check("R7 idle illegalOut", 32'(illegalOut), 32'd0);

    // R10 fill the file
    for (int i = 0; i < 15; i++) preload(4'(i), $urandom);
    preload(4'd0, 32'h7FFF_FFFF);
    preload(4'd1, 32'h8000_0000);
    preload(4'd2, 32'hFFFF_FFFF);
    preload(4'd3, 32'h0000_0001);
    preload(4'd4, 32'h0000_0000);
    preload(4'd5, 32'h0000_00FF);
    preload(4'd9, 32'h8000_0000);
    preload(4'd14, 32'h7FFF_FFFF);

    // Directed corners
    runOp(2'b00, 4'd1, 4'd3, 8'd0);     // R1 signed overflow on subtract
    runOp(2'b00, 4'd0, 4'd0, 8'd0);     // R1 equal: Z and C
    runOp(2'b00, 4'd4, 4'd3, 8'd0);     // R1 borrow
    runOp(2'b10, 4'd0, 4'd3, 8'd0);     // R3 positive overflow
    runOp(2'b10, 4'd2, 4'd3, 8'd0);     // R3 carry out, zero result
    runOp(2'b10, 4'd1, 4'd1, 8'd0);     // R3 carry and overflow
    runOp(2'b01, 4'd5, 4'd15, 8'hFF);   // R2 imm equal, rm ignored
    runOp(2'b01, 4'd4, 4'd7, 8'd1);     // R2 borrow
    runOp(2'b01, 4'd14, 4'd0, 8'd0);    // R2 top legal index
    runOp(2'b00, 4'd9, 4'd14, 8'd0);    // R1 high indices legal for subtract
    runOp(2'b10, 4'd9, 4'd0, 8'd0);     // R5 add with index 9
    runOp(2'b10, 4'd7, 4'd8, 8'd0);     // R5 add with index 8
    runOp(2'b00, 4'd15, 4'd0, 8'd0);    // R6 rn 15
    runOp(2'b00, 4'd0, 4'd15, 8'd0);    // R6 rm 15
    runOp(2'b01, 4'd15, 4'd0, 8'd3);    // R6 imm form rn 15
    runOp(2'b11, 4'd0, 4'd1, 8'd0);     // R6 unused select

    // R7 valid low: no update even with a would-be-different result
    @(negedge clk);
    opSel = 2'b00; rnIdx = 4'd4; rmIdx = 4'd3;
    #1 check("R7 idle illegalOut", 32'(illegalOut), 32'd0);
    @(negedge clk);
    check("R7 idle flags hold", 32'(flagsOut), 32'(expFlags));

    // Random mix
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 9) == 0) begin
        int pick;
        logic [31:0] d;
        pick = $urandom_range(0, 4);
        case (pick)
          0: d = 32'h8000_0000;
          1: d = 32'h7FFF_FFFF;
          2: d = 32'hFFFF_FFFF;
          3: d = 32'h0;
          default: d = $urandom;
        endcase
        preload(4'($urandom_range(0, 14)), d);
      end
      runOp(2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)),
            4'($urandom_range(0, 15)), 8'($urandom_range(0, 255)));
    end

    // R8 compares left every entry intact: compare each against immediate 0
    for (int i = 0; i < 15; i++) begin
      runOp(2'b01, 4'(i), 4'd0, 8'd0);
      check("R8 entry intact", 32'(flagsOut), 32'(calcFlags(1'b0, model[i], 32'd0)));
    end

    // R9 mid-run reset
    runOp(2'b00, 4'd4, 4'd3, 8'd0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 mid-run reset flags", 32'(flagsOut), 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule